// File: doc/BRIEF.md
# ADC Conversion Sequencer with Protection-Mode Scheduling

This block decides which of nine analog signals a shared 10-bit converter samples next. The signals belong to a two-channel power switch. For each channel there is load current, switch temperature, output voltage and drain-to-source voltage, and there is one supply-voltage signal. The sequencer drives the analog mux select and issues a one-cycle start pulse. It then waits for the converter's done pulse and stores the returned code in a per-signal result register. A host reads each result register through a small read port; every register has a valid flag.

In normal operation the block walks the enabled signals in a fixed circular order. After each result it can insert an idle gap, chosen by a 2-bit code, to lower the sampling rate. It powers the current-sense front end only while a current conversion is in flight. When any channel has its integral-current protection both enabled and active, the schedule shrinks to the two current signals, which alternate. In that case the idle gap is skipped, because the protection logic needs fresh current samples. Configuration changes are picked up only when the next signal is chosen, so a conversion in progress always completes.

Top module: `adc_conv_sched`

## Requirements
- R1: Source indices are 0 current ch1, 1 current ch2, 2 temperature ch1, 3 temperature ch2, 4 supply, 5 output voltage ch1, 6 output voltage ch2, 7 drain-source ch1, 8 drain-source ch2. `adc_start` is a single-cycle pulse. `adc_sel` holds the chosen index from that pulse until the done pulse, and no new start is issued before done.
- R2: The enabled sources are converted in ascending index order, wrapping from 8 to 0. Disabled sources are skipped.
- R3: With `glob_en` low, no source is enabled. Once any conversion in flight has finished, `adc_start` and `isns_pwr` stay low.
- R4: `cur_en`, `vout_en` and `vds_en` (bit 0 channel 1, bit 1 channel 2) enable sources 0/1, 5/6 and 7/8. The temperature sources have no per-channel enable; `temp_off` high removes both of them. The supply source depends only on `glob_en`.
- R5: `isns_pwr` is high from the start pulse through the done cycle of a current conversion (source 0 or 1), and low at every other time.
- R6: `dly_code` 0, 1, 2, 3 inserts 0, 16, 64 or 256 idle cycles between a done pulse and the next selection. As a result, the next start follows the done pulse by 2, 18, 66 or 258 cycles.
- R7: When `prot_en[i] & prot_mode[i]` is high for any channel, only sources 0 and 1 are converted, alternating, with no idle gap. The per-channel enables and `temp_off` are then ignored, but `glob_en` still applies.
- R8: Configuration is sampled only at selection. A conversion in progress is never aborted, and its result is stored. Selection resumes from the next enabled index after the last converted one.
- R9: On a done pulse, `adc_data` is written to the current source's result register and its valid flag is set. A cycle with `rd_en` high clears the valid flag of `rd_addr` at the next edge, and the data is kept. After reset, all results are 0 and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_en | input | 1 | Global conversion enable |
| temp_off | input | 1 | Removes both temperature sources |
| cur_en | input | 2 | Per-channel current conversion enable |
| vout_en | input | 2 | Per-channel output-voltage conversion enable |
| vds_en | input | 2 | Per-channel drain-source conversion enable |
| prot_en | input | 2 | Per-channel integral-current protection enable |
| prot_mode | input | 2 | Per-channel protection active indicator |
| dly_code | input | 2 | Idle-gap select |
| adc_sel | output | 4 | Analog mux select (source index) |
| adc_start | output | 1 | Conversion start pulse |
| adc_done | input | 1 | Converter done pulse |
| adc_data | input | 10 | Converter result, valid with done |
| isns_pwr | output | 1 | Current-sense front-end power enable |
| rd_addr | input | 4 | Result register index for reading |
| rd_en | input | 1 | Read strobe, clears the valid flag |
| rd_data | output | 10 | Result of the addressed source |
| rd_valid | output | 1 | Valid flag of the addressed source |

## Verification
The assertions rely on the converter answering each start with exactly one single-cycle done pulse. Done must arrive at least one cycle after the start and must never appear while the sequencer is not converting. `adc_data` must be settled in the done cycle. The bench's converter model waits three cycles after each observed start before it pulses done, and it never produces an unsolicited done. All configuration and read inputs change on the falling edge, so every input is stable at the sampling edge.

// File: rtl/adc_conv_sched.sv
module adc_conv_sched #(
  parameter int DW   = 10,
  parameter int DLY1 = 16,
  parameter int DLY2 = 64,
  parameter int DLY3 = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          glob_en,
  input  logic          temp_off,
  input  logic [1:0]    cur_en,
  input  logic [1:0]    vout_en,
  input  logic [1:0]    vds_en,
  input  logic [1:0]    prot_en,
  input  logic [1:0]    prot_mode,
  input  logic [1:0]    dly_code,
  output logic [3:0]    adc_sel,
  output logic          adc_start,
  input  logic          adc_done,
  input  logic [DW-1:0] adc_data,
  output logic          isns_pwr,
  input  logic [3:0]    rd_addr,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int NSRC = 9;
  localparam int IW   = 4;
  localparam int CW   = $clog2(DLY3 + 1);

  typedef enum logic [1:0] {S_PICK, S_CONV, S_WAIT} st_t;

  st_t             state;
  logic [IW-1:0]   cur, last, nxt;
  logic            start_q;
  logic [CW-1:0]   cnt, dly_len;
  logic [NSRC-1:0] vld, src_mask;
  logic [DW-1:0]   res [NSRC];
  logic            reduced, rd_ok;

  assign reduced = |(prot_en & prot_mode);

  assign src_mask = {NSRC{glob_en}} & (reduced ?
                    {{(NSRC-2){1'b0}}, 2'b11} :
                    {vds_en[1], vds_en[0], vout_en[1], vout_en[0], 1'b1,
                     ~temp_off, ~temp_off, cur_en[1], cur_en[0]});

  always_comb begin
    case (dly_code)
      2'd1:    dly_len = CW'(DLY1);
      2'd2:    dly_len = CW'(DLY2);
      2'd3:    dly_len = CW'(DLY3);
      default: dly_len = '0;
    endcase
  end

  always_comb begin
    logic found;
    found = 1'b0;
    nxt   = last;
    for (int k = 1; k <= NSRC; k++) begin
      int j;
      j = int'(last) + k;
      if (j >= NSRC) j = j - NSRC;
      if (!found && src_mask[j]) begin
        found = 1'b1;
        nxt   = IW'(j);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_PICK;
      cur     <= '0;
      last    <= IW'(NSRC - 1);
      start_q <= 1'b0;
      cnt     <= '0;
      vld     <= '0;
      for (int i = 0; i < NSRC; i++) res[i] <= '0;
    end else begin
      start_q <= 1'b0;
      if (rd_en && rd_ok) vld[rd_addr] <= 1'b0;
      case (state)
        S_PICK: if (|src_mask) begin
          cur     <= nxt;
          start_q <= 1'b1;
          state   <= S_CONV;
        end
        S_CONV: if (adc_done) begin
          res[cur] <= adc_data;
          vld[cur] <= 1'b1;
          last     <= cur;
          if (!reduced && dly_len != '0) begin
            cnt   <= dly_len - CW'(1);
            state <= S_WAIT;
          end else begin
            state <= S_PICK;
          end
        end
        S_WAIT: if (reduced || cnt == '0) state <= S_PICK;
                else cnt <= cnt - CW'(1);
        default: state <= S_PICK;
      endcase
    end
  end

  assign adc_sel   = cur;
  assign adc_start = start_q;
  assign isns_pwr  = (state == S_CONV) && (cur < IW'(2));
  assign rd_ok     = rd_addr < IW'(NSRC);
  assign rd_data   = rd_ok ? res[rd_addr] : '0;
  assign rd_valid  = rd_ok ? vld[rd_addr] : 1'b0;

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start); // R1
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CONV && !adc_done) |=> $stable(adc_sel)); // R1
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PICK && src_mask == '0) |=> !adc_start); // R3
  AST_PWR_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isns_pwr) |-> adc_start); // R5
  AST_REDUCED_CUR: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && $past(reduced)) |-> (adc_sel < IW'(2))); // R7
  AST_REDUCED_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CONV && adc_done && reduced) |=> state == S_PICK); // R7
  AST_WRITE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CONV && adc_done) |=> vld[$past(cur)]); // R9
endmodule

// File: tb/adc_conv_sched_bench.sv
`timescale 1ns/1ps
module adc_conv_sched_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic glob_en = 1'b0, temp_off = 1'b0, rd_en = 1'b0, adc_done = 1'b0;
  logic [1:0] cur_en = 2'b11, vout_en = 2'b11, vds_en = 2'b11;
  logic [1:0] prot_en = 2'b00, prot_mode = 2'b00, dly_code = 2'd0;
  logic [3:0] adc_sel, rd_addr = 4'd0;
  logic [9:0] adc_data = '0, rd_data;
  logic adc_start, isns_pwr, rd_valid;

  int total = 0, bad = 0;
  int n = 0, cyc = 0, done_cyc = 0, pend = 0, cur_sel = 0;
  int pwr_err = 0, ovl_err = 0;
  bit busy = 0;
  int log_sel [1024];
  int log_gap [1024];

  always #2.5 clk = ~clk;

  adc_conv_sched u_adc_conv_sched (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .temp_off(temp_off),
    .cur_en(cur_en), .vout_en(vout_en), .vds_en(vds_en),
    .prot_en(prot_en), .prot_mode(prot_mode), .dly_code(dly_code),
    .adc_sel(adc_sel), .adc_start(adc_start), .adc_done(adc_done),
    .adc_data(adc_data), .isns_pwr(isns_pwr), .rd_addr(rd_addr),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic int mval(int s);
    return s * 73 + 11;
  endfunction

  function automatic int nxt_in(logic [8:0] m, int p);
    for (int k = 1; k <= 9; k++) begin
      int j;
      j = (p + k) % 9;
      if (m[j]) return j;
    end
    return p;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: answers each start with done three cycles later
  initial begin
    forever begin
      bit clr;
      @(negedge clk);
      cyc++;
      clr = 0;
      adc_done = 1'b0;
      if (adc_start) begin
        if (busy) ovl_err++;
        if (n < 1024) begin
          log_sel[n] = int'(adc_sel);
          log_gap[n] = cyc - done_cyc;
        end
        n++;
        pend = 3;
        cur_sel = int'(adc_sel);
        busy = 1;
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          adc_done = 1'b1;
          adc_data = 10'(mval(cur_sel));
          done_cyc = cyc;
          clr = 1;
        end
      end
      if (isns_pwr != (busy && cur_sel < 2)) pwr_err++;
      if (clr) busy = 0;
    end
  end

  // {glob,toff,cur,vout,vds,pen,pmode,dly, mask[8:0], gap[8:0]}
  localparam logic [31:0] VEC [9] = '{
    {1'b1,1'b0,2'b11,2'b11,2'b11,2'b00,2'b00,2'd0, 9'h1FF, 9'd2},
    {1'b1,1'b0,2'b11,2'b11,2'b11,2'b00,2'b00,2'd1, 9'h1FF, 9'd18},
    {1'b1,1'b1,2'b11,2'b11,2'b11,2'b00,2'b00,2'd0, 9'h1F3, 9'd2},
    {1'b1,1'b0,2'b01,2'b10,2'b00,2'b00,2'b00,2'd0, 9'h05D, 9'd2},
    {1'b1,1'b0,2'b11,2'b11,2'b11,2'b01,2'b01,2'd3, 9'h003, 9'd2},
    {1'b1,1'b0,2'b11,2'b11,2'b11,2'b00,2'b11,2'd2, 9'h1FF, 9'd66},
    {1'b1,1'b1,2'b00,2'b00,2'b00,2'b10,2'b10,2'd1, 9'h003, 9'd2},
    {1'b1,1'b0,2'b11,2'b11,2'b11,2'b10,2'b01,2'd0, 9'h1FF, 9'd2},
    {1'b1,1'b0,2'b11,2'b11,2'b11,2'b00,2'b00,2'd3, 9'h1FF, 9'd258}
  };

  task automatic apply(logic [13:0] c);
    {glob_en, temp_off, cur_en, vout_en, vds_en, prot_en, prot_mode, dly_code} = c;
  endtask

  task automatic wait_starts(int k);
    int t;
    t = n + k;
    while (n < t) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int vb, vr, s0, s1, n0, idle_err;
    logic [8:0] m;
    // reset state (R9, R3)
    repeat (3) @(negedge clk);
    vb = 0;
    for (int a = 0; a < 9; a++) begin
      rd_addr = 4'(a);
      #0.1;
      if (rd_valid || rd_data != 0) vb++;
    end
    chk(vb == 0, "R9 reset results", vb, 0);
    chk(!adc_start && !isns_pwr, "R3 reset outputs", int'(adc_start), 0);
    rst_n = 1'b1;

    // vector walk (R2 R4 R6 R7)
    for (int v = 0; v < 9; v++) begin
      int base, oe, ge;
      @(negedge clk);
      apply(VEC[v][31:18]);
      m = VEC[v][17:9];
      wait_starts(2);
      @(negedge clk);
      base = n - 1;
      wait_starts(10);
      @(negedge clk);
      oe = 0; ge = 0;
      for (int i = base + 1; i <= base + 9; i++) begin
        if (!m[log_sel[i]] || log_sel[i] != nxt_in(m, log_sel[i-1])) oe++;
        if (log_gap[i] != int'(VEC[v][8:0])) begin
          ge++;
          if (ge == 1) $display("vector %0d gap %0d", v, log_gap[i]);
        end
      end
      chk(oe == 0, $sformatf("R2/R4/R7 order vector %0d", v), oe, 0);
      chk(ge == 0, $sformatf("R6/R7 gap vector %0d", v), ge, 0);
    end

    // pointer resumes after last converted (R8)
    @(negedge clk);
    apply({1'b1,1'b0,2'b11,2'b11,2'b11,2'b00,2'b00,2'd0});
    do @(negedge clk); while (!(adc_start && adc_sel == 4'd5));
    prot_en = 2'b01; prot_mode = 2'b01;
    do @(negedge clk); while (!adc_start);
    s0 = int'(adc_sel);
    chk(s0 == 0, "R8 resume into reduced", s0, 0);
    do @(negedge clk); while (!(adc_start && adc_sel == 4'd1));
    prot_en = 2'b00;
    do @(negedge clk); while (!adc_start);
    s1 = int'(adc_sel);
    chk(s1 == 2, "R8 resume into full", s1, 2);

    // drain and clear all valid flags (R9)
    glob_en = 1'b0;
    repeat (600) @(negedge clk);
    for (int a = 0; a < 9; a++) begin
      rd_addr = 4'(a); rd_en = 1'b1;
      @(negedge clk);
    end
    rd_en = 1'b0; rd_addr = 4'd4;
    #0.1;
    chk(!rd_valid, "R9 cleared flag", int'(rd_valid), 0);

    // supply-only, disable mid conversion (R4 R8)
    apply({1'b1,1'b1,2'b00,2'b00,2'b00,2'b00,2'b00,2'd0});
    do @(negedge clk); while (!adc_start);
    glob_en = 1'b0;
    chk(adc_sel == 4'd4, "R4 supply only", int'(adc_sel), 4);
    repeat (20) @(negedge clk);
    rd_addr = 4'd4;
    #0.1;
    chk(rd_valid, "R8 in-flight completes", int'(rd_valid), 1);
    chk(rd_data == 10'(mval(4)), "R9 stored data", int'(rd_data), mval(4));

    // everything off stays idle (R3)
    n0 = n; idle_err = 0;
    repeat (400) begin
      @(negedge clk);
      if (adc_start || isns_pwr) idle_err++;
    end
    chk(idle_err == 0 && n == n0, "R3 idle when disabled", n - n0, 0);

    // read clears flag, keeps data (R9)
    @(negedge clk);
    rd_addr = 4'd4; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    #0.1;
    vr = int'(rd_valid);
    chk(vr == 0, "R9 read clears flag", vr, 0);
    chk(rd_data == 10'(mval(4)), "R9 data kept after read", int'(rd_data), mval(4));

    chk(pwr_err == 0, "R5 current-sense power window", pwr_err, 0);
    chk(ovl_err == 0, "R1 no start before done", ovl_err, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule